// File: doc/BRIEF.md
# Video Decoder Register Load Sequencer

After reset, a video decoder needs a fixed set of configuration values before it produces a picture. This block holds those values in two constant tables and writes them to the decoder over I2C. Each table is sent as its own burst write. The sequencer does not drive the bus pins. It issues byte-level commands to a separate I2C write engine and reads back one acknowledge result for every byte written.

One pulse on `start` runs the whole load. The first burst writes the device address, then sub-address 0x00, then 26 data bytes, which fill registers 0x00 to 0x19. A stop and a fresh start follow. The second burst writes the device address, then sub-address 0x20, then 21 data bytes, which fill registers 0x20 to 0x34. The unused registers 0x1A to 0x1F are skipped and never written. The decoder's pointer advances by itself after each data byte, so no further addressing is needed inside a burst.

A missing acknowledge ends the load early. The sequencer closes the bus with a stop and reports the failure through a sticky `error` output. `done` marks the end of a load, whether it completed or was cut short.

Top module: `i2c_init_seq`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `done`, `error` and `cmd_valid` are all 0.
- R2: A `start` pulse seen while idle raises `busy` on the next cycle. A `start` seen while `busy` is high is ignored and does not change the command stream.
- R3: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_op` and `cmd_data` hold their values on the next cycle. A command is taken on a cycle where both are 1. The `cmd_op` encoding is 1 = start condition, 2 = write byte, 3 = stop condition.
- R4: The full command stream has 55 commands: start, write 0x9C, write 0x00, 26 data writes, stop, start, write 0x9C, write 0x20, 21 data writes, stop.
- R5: The data bytes follow the built-in tables. The first table begins with 0x4C and ends with 0x9B, and its 14th byte (register 0x0D) is 0x86. The second table begins with 0x7C and ends with 0x03.
- R6: After a write command is taken, `cmd_valid` stays 0 until the engine returns that byte's result on `rsp_valid`.
- R7: A result with `rsp_nack` = 1 makes the next command a stop. No further writes or starts follow, and the load ends with `done` = 1 and `error` = 1.
- R8: `done` and `error` keep their values until the next accepted `start`, which clears both.
- R9: `done` rises in the same cycle that `busy` falls, one cycle after the final stop is taken. After a clean load, `error` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a register load |
| busy | output | 1 | High from the accepted start until done |
| done | output | 1 | Load finished (sticky until next start) |
| error | output | 1 | A byte was not acknowledged (sticky until next start) |
| cmd_valid | output | 1 | Command to the write engine is valid |
| cmd_ready | input | 1 | Engine accepts the current command |
| cmd_op | output | 2 | 1 start, 2 write byte, 3 stop |
| cmd_data | output | 8 | Byte for a write command |
| rsp_valid | input | 1 | One-cycle result for the last written byte |
| rsp_nack | input | 1 | 1 means the byte was not acknowledged |

## Verification
Some properties are checked on every cycle. These are the command hold under back-pressure, the silent gap after each write until its result arrives, the stop that must follow a nack, and the alignment of `done` with the falling edge of `busy`. Other behaviour only the bench scenarios can show, because it depends on the whole stream. This covers the exact order and content of all 55 commands, the early end after a nack in either burst, a second `start` having no effect mid-load, and the flags staying put until a new load clears them.

// File: rtl/i2c_init_pkg.sv
package i2c_init_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_START = 2'd1,
    OP_WRITE = 2'd2,
    OP_STOP  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_BYTE,
    S_ACK,
    S_STOP
  } state_e;

  // Decoder setup values for the low register window, by offset
  function automatic logic [7:0] low_window(input int unsigned idx);
    case (idx)
      0:  return 8'h4C;  1:  return 8'h3C;  2:  return 8'h0D;  3:  return 8'hEF;
      4:  return 8'hBD;  5:  return 8'hF0;  6:  return 8'h00;  7:  return 8'h00;
      8:  return 8'hF8;  9:  return 8'hF8;  10: return 8'h60;  11: return 8'h50;
      12: return 8'h00;  13: return 8'h86;  14: return 8'h18;  15: return 8'h90;
      16: return 8'h00;  17: return 8'h2C;  18: return 8'h7F;  19: return 8'h5E;
      20: return 8'h42;  21: return 8'h1A;  22: return 8'hFF;  23: return 8'hDA;
      24: return 8'hF0;  25: return 8'h9B;
      default: return 8'h00;
    endcase
  endfunction

  // Decoder setup values for the high register window, by offset
  function automatic logic [7:0] high_window(input int unsigned idx);
    case (idx)
      0:  return 8'h7C;  1:  return 8'h03;  2:  return 8'hD2;  3:  return 8'h41;
      4:  return 8'h80;  5:  return 8'h41;  6:  return 8'h80;  7:  return 8'h4F;
      8:  return 8'hFE;  9:  return 8'h01;  10: return 8'hCF;  11: return 8'h0F;
      12: return 8'h83;  13: return 8'h01;  14: return 8'h81;  15: return 8'h03;
      16: return 8'h60;  17: return 8'h71;  18: return 8'h02;  19: return 8'h8C;
      20: return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  // Position in a burst: 0 = device address, 1 = sub-address, 2.. = data
  function automatic logic [7:0] burst_byte(input logic [7:0] dev, input logic [7:0] sub,
                                            input logic [7:0] payload, input int unsigned pos);
    if (pos == 0) return dev;
    if (pos == 1) return sub;
    return payload;
  endfunction

  // Index of the last position of a burst carrying n data bytes
  function automatic int unsigned last_pos(input int unsigned n);
    return n + 1;
  endfunction

endpackage

// File: rtl/init_rom.sv
module init_rom
  import i2c_init_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'h9C,
  parameter logic [7:0] SUB_LO   = 8'h00,
  parameter logic [7:0] SUB_HI   = 8'h20,
  parameter int         PW       = 5
) (
  input  logic          burst_sel,
  input  logic [PW-1:0] pos,
  output logic [7:0]    byte_out
);

  localparam int NB = 2;

  logic [7:0] cand [NB];

  for (genvar g = 0; g < NB; g++) begin : g_burst
    logic [7:0] payload;
    always_comb begin
      if (g == 0) payload = low_window(int'(pos) - 2);
      else        payload = high_window(int'(pos) - 2);
      cand[g] = burst_byte(DEV_ADDR, (g == 0) ? SUB_LO : SUB_HI, payload, int'(pos));
    end
  end

  assign byte_out = cand[burst_sel];

endmodule

// File: rtl/init_cursor.sv
module init_cursor
  import i2c_init_pkg::*;
#(
  parameter int LEN_LO = 26,
  parameter int LEN_HI = 21,
  parameter int PW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic          next_burst,
  output logic          burst_sel,
  output logic [PW-1:0] pos,
  output logic          at_last_pos,
  output logic          in_last_burst
);

  localparam logic [PW-1:0] END_LO = PW'(last_pos(LEN_LO));
  localparam logic [PW-1:0] END_HI = PW'(last_pos(LEN_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_sel <= 1'b0;
      pos       <= '0;
    end else if (clear) begin
      burst_sel <= 1'b0;
      pos       <= '0;
    end else if (next_burst) begin
      burst_sel <= 1'b1;
      pos       <= '0;
    end else if (step) begin
      pos <= pos + 1'b1;
    end
  end

  assign at_last_pos   = (pos == (burst_sel ? END_HI : END_LO));
  assign in_last_burst = burst_sel;

endmodule

// File: rtl/init_fsm.sv
module init_fsm
  import i2c_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cmd_ready,
  input  logic       rsp_valid,
  input  logic       rsp_nack,
  input  logic       at_last_pos,
  input  logic       in_last_burst,
  output logic       cmd_valid,
  output logic [1:0] cmd_op,
  output logic       clear,
  output logic       step,
  output logic       next_burst,
  output logic       busy,
  output logic       done,
  output logic       error
);

  state_e state;
  logic   abort;
  logic   fire;
  logic   finish;

  assign fire   = cmd_valid && cmd_ready;
  assign finish = (state == S_STOP) && fire && (abort || in_last_burst);

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = OP_NONE;
    case (state)
      S_START: begin cmd_valid = 1'b1; cmd_op = OP_START; end
      S_BYTE:  begin cmd_valid = 1'b1; cmd_op = OP_WRITE; end
      S_STOP:  begin cmd_valid = 1'b1; cmd_op = OP_STOP;  end
      default: ;
    endcase
  end

  assign clear      = (state == S_IDLE) && start;
  assign step       = (state == S_ACK) && rsp_valid && !rsp_nack && !at_last_pos;
  assign next_burst = (state == S_STOP) && fire && !abort && !in_last_burst;
  assign busy       = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      abort <= 1'b0;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_START;
          abort <= 1'b0;
          done  <= 1'b0;
          error <= 1'b0;
        end
        S_START: if (fire) state <= S_BYTE;
        S_BYTE:  if (fire) state <= S_ACK;
        S_ACK: if (rsp_valid) begin
          if (rsp_nack) begin
            abort <= 1'b1;
            state <= S_STOP;
          end else if (at_last_pos) begin
            state <= S_STOP;
          end else begin
            state <= S_BYTE;
          end
        end
        S_STOP: if (fire) begin
          if (finish) begin
            state <= S_IDLE;
            done  <= 1'b1;
            error <= abort;
          end else begin
            state <= S_START;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_init_seq.sv
module i2c_init_seq
  import i2c_init_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'h9C,
  parameter logic [7:0] SUB_LO   = 8'h00,
  parameter logic [7:0] SUB_HI   = 8'h20,
  parameter int         LEN_LO   = 26,
  parameter int         LEN_HI   = 21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output logic       error,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [1:0] cmd_op,
  output logic [7:0] cmd_data,
  input  logic       rsp_valid,
  input  logic       rsp_nack
);

  localparam int MAXLEN = (LEN_LO > LEN_HI) ? LEN_LO : LEN_HI;
  localparam int PW     = $clog2(MAXLEN + 2);

  logic          clear, step, next_burst;
  logic          burst_sel, at_last_pos, in_last_burst;
  logic [PW-1:0] pos;
  logic [7:0]    rom_byte;

  // Named events for the checker
  logic cmd_fire, rsp_fire;
  assign cmd_fire = cmd_valid && cmd_ready;
  assign rsp_fire = rsp_valid;

  init_cursor #(.LEN_LO(LEN_LO), .LEN_HI(LEN_HI), .PW(PW)) u_cursor (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step(step), .next_burst(next_burst),
    .burst_sel(burst_sel), .pos(pos), .at_last_pos(at_last_pos), .in_last_burst(in_last_burst)
  );

  init_rom #(.DEV_ADDR(DEV_ADDR), .SUB_LO(SUB_LO), .SUB_HI(SUB_HI), .PW(PW)) u_rom (
    .burst_sel(burst_sel), .pos(pos), .byte_out(rom_byte)
  );

  init_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .at_last_pos(at_last_pos),
    .in_last_burst(in_last_burst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .clear(clear), .step(step), .next_burst(next_burst),
    .busy(busy), .done(done), .error(error)
  );

  assign cmd_data = (cmd_op == OP_WRITE) ? rom_byte : 8'h00;

endmodule

// File: rtl/i2c_init_seq_chk.sv
module i2c_init_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_data,
  input logic       cmd_fire,
  input logic       rsp_fire,
  input logic       rsp_nack
);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3
  hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_data)));

  // R6
  quiet_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_op == 2'd2) |=> !cmd_valid);

  // R7
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire && rsp_nack && busy) |=> (cmd_valid && cmd_op == 2'd3));

  // R9
  done_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

endmodule

bind i2c_init_seq i2c_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
  .cmd_fire(cmd_fire), .rsp_fire(rsp_fire), .rsp_nack(rsp_nack)
);

// File: tb/test_i2c_init_seq.sv
`timescale 1ns/1ps
module test_i2c_init_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       busy, done, error, cmd_valid;
  logic       cmd_ready, rsp_valid, rsp_nack;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;

  always #2 clk = ~clk;

  i2c_init_seq i_i2c_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .error(error),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected register contents, kept apart from the design
  logic [7:0] tbl_lo [26] = '{8'h4C,8'h3C,8'h0D,8'hEF,8'hBD,8'hF0,8'h00,8'h00,8'hF8,8'hF8,
                              8'h60,8'h50,8'h00,8'h86,8'h18,8'h90,8'h00,8'h2C,8'h7F,8'h5E,
                              8'h42,8'h1A,8'hFF,8'hDA,8'hF0,8'h9B};
  logic [7:0] tbl_hi [21] = '{8'h7C,8'h03,8'hD2,8'h41,8'h80,8'h41,8'h80,8'h4F,8'hFE,8'h01,
                              8'hCF,8'h0F,8'h83,8'h01,8'h81,8'h03,8'h60,8'h71,8'h02,8'h8C,
                              8'h03};

  // Expected {op,data} of command k in a clean load
  function automatic logic [9:0] exp_cmd(input int k);
    if (k == 0 || k == 30)  return {2'd1, 8'h00};
    if (k == 29 || k == 54) return {2'd3, 8'h00};
    if (k == 1 || k == 31)  return {2'd2, 8'h9C};
    if (k == 2)             return {2'd2, 8'h00};
    if (k == 32)            return {2'd2, 8'h20};
    if (k < 29)             return {2'd2, tbl_lo[k-3]};
    return {2'd2, tbl_hi[k-33]};
  endfunction

  // Engine model
  int         cyc = 0, gap = 0, lat = 0, nack_at = -1;
  logic [9:0] log_q [128];
  int         log_n = 0, wr_n = 0, viol6 = 0, cnt = 0;
  bit         pending = 0, pend_nack = 0;

  initial begin
    cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_nack = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (pending && cmd_valid) viol6++;
      rsp_valid = 1'b0; rsp_nack = 1'b0;
      if (pending) begin
        if (cnt == 0) begin
          rsp_valid = 1'b1; rsp_nack = pend_nack; pending = 0;
        end else cnt--;
      end
      cmd_ready = rst_n && ((cyc % (gap + 1)) == 0);
      if (cmd_valid && cmd_ready) begin
        if (log_n < 128) log_q[log_n] = {cmd_op, (cmd_op == 2'd2) ? cmd_data : 8'h00};
        log_n++;
        if (cmd_op == 2'd2) begin
          pending = 1; cnt = lat; pend_nack = (wr_n == nack_at); wr_n++;
        end
      end
    end
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic prep(input int g, input int l, input int na);
    gap = g; lat = l; nack_at = na; log_n = 0; wr_n = 0; viol6 = 0;
  endtask

  task automatic wait_done(output bit was_busy);
    was_busy = 0;
    for (int i = 0; i < 20000; i++) begin
      if (done) break;
      was_busy = busy;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check(!busy && !done && !error && !cmd_valid, "R1 reset outputs",
          {busy, done, error, cmd_valid}, 0);
  endtask

  task automatic t_full(input int g, input int l, input bit restart);
    bit wb;
    int bad = 0;
    prep(g, l, -1);
    @(negedge clk);
    pulse_start();
    check(busy, "R2 busy after start", busy, 1);
    if (restart) begin
      repeat (40) @(negedge clk);
      pulse_start();
    end
    wait_done(wb);
    check(done && !busy && wb, "R9 done as busy falls", {done, busy, wb}, 3'b101);
    check(!error, "R9 clean load no error", error, 0);
    check(log_n == 55, restart ? "R2 restart ignored count" : "R4 command count", log_n, 55);
    for (int k = 0; k < 55 && k < log_n; k++)
      if (log_q[k] != exp_cmd(k)) bad++;
    check(bad == 0, "R4 command order", bad, 0);
    check(log_q[3][7:0] == 8'h4C && log_q[16][7:0] == 8'h86 && log_q[28][7:0] == 8'h9B,
          "R5 low table", log_q[16][7:0], 8'h86);
    check(log_q[33][7:0] == 8'h7C && log_q[53][7:0] == 8'h03, "R5 high table",
          log_q[33][7:0], 8'h7C);
    check(viol6 == 0, "R6 no command while awaiting result", viol6, 0);
  endtask

  task automatic t_nack(input int na, input int exp_n);
    bit wb;
    int bad = 0;
    prep(1, 2, na);
    @(negedge clk);
    pulse_start();
    wait_done(wb);
    check(done && error, "R7 done and error", {done, error}, 2'b11);
    check(log_n == exp_n, "R7 command count", log_n, exp_n);
    for (int k = 0; k < exp_n - 1 && k < log_n; k++)
      if (log_q[k] != exp_cmd(k)) bad++;
    check(bad == 0, "R7 prefix", bad, 0);
    check(log_n >= 1 && log_q[log_n-1] == {2'd3, 8'h00}, "R7 final stop",
          log_q[log_n-1], {2'd3, 8'h00});
  endtask

  task automatic t_sticky();
    repeat (20) @(negedge clk);
    check(done && error, "R8 flags held", {done, error}, 2'b11);
    prep(0, 0, -1);
    pulse_start();
    check(!done && !error && busy, "R8 start clears", {done, error, busy}, 3'b001);
    begin : drain
      bit wb;
      wait_done(wb);
    end
    check(done && !error && log_n == 55, "R8 reload completes", log_n, 55);
  endtask

  initial begin
    bit timeout = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full(0, 0, 0);
        t_full(2, 3, 0);
        t_full(1, 1, 1);
        t_nack(0, 3);
        t_nack(30, 35);
        t_sticky();
      end
      begin
        repeat (150000) @(negedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) check(0, "watchdog", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule